// File: doc/BRIEF.md
# Cascaded Fixed-Point Acoustic Wave Stencil

This block advances a two-dimensional pressure field through several time steps of the second-order acoustic wave equation in one streaming pass. Grid points arrive in raster order, several adjacent points per beat. Each point carries three words: its present pressure, its pressure one step earlier, and a velocity coefficient that already folds in the time and space step sizes. A new pressure is formed from twice the present value, minus the earlier value, plus the velocity coefficient times a five-point cross Laplacian.

A chain of identical stage modules does the work. Each stage holds two row-length line buffers to build the stencil window. It emits, for every point, the new pressure together with the pressure it replaced and the unchanged velocity word. That is exactly the input the next stage needs to compute the following time step. Row length (in beats) and row count are set at run time. All words are signed pure fractions, and results outside the representable range are clamped.

Top module: `wave_stencil_chain`

## Requirements
- R1: Every pressure and velocity word is 24-bit two's complement with the sign in the most significant bit and 23 fraction bits, so a code k stands for k/2^23 and the range is -1 up to 1-2^-23.
- R2: For an interior point with centre c, axial neighbours n, s, w, e, earlier value p and velocity v, a stage produces 2c - p + round(v*(n+s+w+e-4c)). The product is kept at full width and rounded to 23 fraction bits by adding 2^22 and shifting right arithmetically.
- R3: A stage result above 0x7FFFFF becomes 0x7FFFFF, and a result below -2^23 (0x800000) becomes 0x800000.
- R4: Points in the first or last row, or in the first or last column, leave a stage with their present pressure unchanged.
- R5: For each point, out_prev carries the pressure that the last stage received as present pressure, and out_vel carries the velocity word unchanged.
- R6: Each beat holds LANES adjacent points of one row, with lane i (bits 24*i+23 down to 24*i) at column beat*LANES+i. Beats run row by row, left to right, cfg_beats beats per row and cfg_rows rows per frame.
- R7: Each output point equals STAGES successive applications of the R2 to R4 update to the input field.
- R8: While out_valid is high and out_ready is low, out_valid and all output data hold their values, and no beat is lost or duplicated under any pattern of input gaps and output stalls.
- R9: Each frame produces exactly cfg_rows*cfg_beats output beats, in the same order as the input. Frames may follow each other back to back, and output never runs ahead of input.
- R10: Synchronous active-high reset empties the chain. After reset out_valid is low and, with non-zero configuration, in_ready is high, even if a frame was in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_beats | input | 5 | Beats per grid row (1 to MAX_BEATS), held stable during a frame |
| cfg_rows | input | 7 | Rows per frame (1 to MAX_ROWS), held stable during a frame |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Chain accepts the input beat |
| in_cur | input | 96 | Present pressure, LANES words |
| in_prev | input | 96 | Pressure one step earlier, LANES words |
| in_vel | input | 96 | Velocity coefficients, LANES words |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_cur | output | 96 | Pressure after STAGES steps |
| out_prev | output | 96 | Pressure after STAGES-1 steps |
| out_vel | output | 96 | Velocity coefficients passed through |

## Verification
Two functions can meet in the same cycle. The first is the end-of-frame flush, in which a stage drains its last row without taking input. The second is downstream backpressure, which freezes the output register. The bench provokes this by streaming two frames back to back under several stall patterns, so that output stalls land while stages are flushing one frame and starting the next. Every delivered beat is compared with an independent fixed-point model, and the held output is compared with its previous value on each stalled cycle. Edge pass-through and saturation also share beats in the clamping case, where boundary lanes and saturated interior lanes travel side by side.

// File: rtl/wave_pkg.sv
`timescale 1ns/1ps
package wave_pkg;
  localparam int WORD_W = 24;
  localparam int FRAC_W = WORD_W - 1;
  typedef logic signed [WORD_W-1:0] word_t;
  localparam word_t WORD_MAX = {1'b0, {FRAC_W{1'b1}}};
  localparam word_t WORD_MIN = {1'b1, {FRAC_W{1'b0}}};
endpackage

// File: rtl/wave_pe.sv
`timescale 1ns/1ps
// One point update: explicit second-order scheme, 5-point Laplacian.
module wave_pe
  import wave_pkg::*;
(
  input  word_t ctr,
  input  word_t up,
  input  word_t dn,
  input  word_t lf,
  input  word_t rt,
  input  word_t old,
  input  word_t vel,
  input  logic  is_bnd,
  output word_t nxt
);
  localparam int LAP_W  = WORD_W + 4;
  localparam int PROD_W = WORD_W + LAP_W;
  localparam int SUM_W  = PROD_W + 2;
  localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) <<< (FRAC_W - 1);

  logic signed [LAP_W-1:0]  lap;
  logic signed [PROD_W-1:0] prod, rnd;
  logic signed [SUM_W-1:0]  sum;

  always_comb begin
    lap  = LAP_W'(up) + LAP_W'(dn) + LAP_W'(lf) + LAP_W'(rt) - (LAP_W'(ctr) <<< 2);
    prod = PROD_W'(vel) * PROD_W'(lap);
    rnd  = (prod + HALF) >>> FRAC_W;
    sum  = SUM_W'(ctr) + SUM_W'(ctr) - SUM_W'(old) + SUM_W'(rnd);
    if (is_bnd)
      nxt = ctr;
    else if (sum > SUM_W'(WORD_MAX))
      nxt = WORD_MAX;
    else if (sum < SUM_W'(WORD_MIN))
      nxt = WORD_MIN;
    else
      nxt = sum[WORD_W-1:0];
  end
endmodule

// File: rtl/wave_stage.sv
`timescale 1ns/1ps
// One time step. Output point j is formed at step j+beats+1.
module wave_stage
  import wave_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int MAX_BEATS = 16,
  parameter int MAX_ROWS  = 64,
  localparam int BW = $clog2(MAX_BEATS + 1),
  localparam int RW = $clog2(MAX_ROWS + 1),
  localparam int LW = LANES * WORD_W
)(
  input  logic          clk,
  input  logic          rst,
  input  logic [BW-1:0] cfg_beats,
  input  logic [RW-1:0] cfg_rows,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [LW-1:0] in_cur,
  input  logic [LW-1:0] in_prev,
  input  logic [LW-1:0] in_vel,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [LW-1:0] out_cur,
  output logic [LW-1:0] out_prev,
  output logic [LW-1:0] out_vel
);
  localparam int KW = $clog2((MAX_ROWS + 1) * MAX_BEATS + 2);
  localparam int PW = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1;

  logic [KW-1:0]   step, n_in, n_all;
  logic [PW-1:0]   ptr;
  logic [BW-1:0]   ob;
  logic [RW-1:0]   orow;
  logic            flushing, producing, last_step, ptr_last, space, adv;
  logic            row_first, row_last, beat_first, beat_last;
  logic [3*LW-1:0] in_word, rd1, c1;
  logic [LW-1:0]   rd2, c2, u1, d1, c1_cur, c1_prev, c1_vel, rd1_cur, nxt_beat;

  // two line buffers: lb1 holds whole points, lb2 pressure one row older
  logic [3*LW-1:0] lb1 [MAX_BEATS];
  logic [LW-1:0]   lb2 [MAX_BEATS];

  always_comb begin
    n_in      = KW'(cfg_rows) * KW'(cfg_beats);
    n_all     = n_in + KW'(cfg_beats) + KW'(1);
    flushing  = step >= n_in;
    producing = step > KW'(cfg_beats);
    last_step = step == n_all - KW'(1);
    ptr_last  = ptr == PW'(cfg_beats - BW'(1));
    space     = !out_valid || out_ready;
    adv       = space && (flushing || in_valid);
    in_ready  = space && !flushing;
    in_word   = flushing ? '0 : {in_cur, in_prev, in_vel};
    rd1       = lb1[ptr];
    rd2       = lb2[ptr];
    rd1_cur   = rd1[3*LW-1 -: LW];
    c1_cur    = c1[3*LW-1 -: LW];
    c1_prev   = c1[2*LW-1 -: LW];
    c1_vel    = c1[LW-1:0];
    row_first  = orow == '0;
    row_last   = orow == cfg_rows - RW'(1);
    beat_first = ob == '0;
    beat_last  = ob == cfg_beats - BW'(1);
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      lb1[ptr] <= in_word;
      lb2[ptr] <= rd1_cur;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      c1 <= rd1;
      c2 <= c1_cur;
      u1 <= rd2;
      d1 <= in_word[3*LW-1 -: LW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step <= '0;
      ptr  <= '0;
      ob   <= '0;
      orow <= '0;
    end else if (adv) begin
      if (last_step) begin
        step <= '0;
        ptr  <= '0;
        ob   <= '0;
        orow <= '0;
      end else begin
        step <= step + KW'(1);
        ptr  <= ptr_last ? '0 : ptr + PW'(1);
        if (producing) begin
          ob   <= beat_last ? '0 : ob + BW'(1);
          orow <= orow + RW'(beat_last);
        end
      end
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    word_t lf, rt, nxt;
    logic  is_bnd;
    if (i == 0) begin : g_lf_wrap
      assign lf = c2[(LANES-1)*WORD_W +: WORD_W];
    end else begin : g_lf_in
      assign lf = c1_cur[(i-1)*WORD_W +: WORD_W];
    end
    if (i == LANES - 1) begin : g_rt_wrap
      assign rt = rd1_cur[WORD_W-1:0];
    end else begin : g_rt_in
      assign rt = c1_cur[(i+1)*WORD_W +: WORD_W];
    end
    assign is_bnd = row_first || row_last || (i == 0 && beat_first) ||
                    (i == LANES - 1 && beat_last);
    wave_pe u_pe (
      .ctr   (c1_cur[i*WORD_W +: WORD_W]),
      .up    (u1[i*WORD_W +: WORD_W]),
      .dn    (d1[i*WORD_W +: WORD_W]),
      .lf    (lf),
      .rt    (rt),
      .old   (c1_prev[i*WORD_W +: WORD_W]),
      .vel   (c1_vel[i*WORD_W +: WORD_W]),
      .is_bnd(is_bnd),
      .nxt   (nxt)
    );
    assign nxt_beat[i*WORD_W +: WORD_W] = nxt;
  end

  always_ff @(posedge clk) begin
    if (rst)
      out_valid <= 1'b0;
    else if (adv && producing)
      out_valid <= 1'b1;
    else if (out_ready)
      out_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (adv && producing) begin
      out_cur  <= nxt_beat;
      out_prev <= c1_cur;
      out_vel  <= c1_vel;
    end
  end
endmodule

// File: rtl/wave_stencil_chain.sv
`timescale 1ns/1ps
module wave_stencil_chain
  import wave_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int STAGES    = 3,
  parameter int MAX_BEATS = 16,
  parameter int MAX_ROWS  = 64,
  localparam int BW = $clog2(MAX_BEATS + 1),
  localparam int RW = $clog2(MAX_ROWS + 1),
  localparam int LW = LANES * WORD_W
)(
  input  logic          clk,
  input  logic          rst,
  input  logic [BW-1:0] cfg_beats,
  input  logic [RW-1:0] cfg_rows,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [LW-1:0] in_cur,
  input  logic [LW-1:0] in_prev,
  input  logic [LW-1:0] in_vel,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [LW-1:0] out_cur,
  output logic [LW-1:0] out_prev,
  output logic [LW-1:0] out_vel
);
  logic          lk_valid [STAGES+1];
  logic          lk_ready [STAGES+1];
  logic [LW-1:0] lk_cur   [STAGES+1];
  logic [LW-1:0] lk_prev  [STAGES+1];
  logic [LW-1:0] lk_vel   [STAGES+1];

  assign lk_valid[0]      = in_valid;
  assign lk_cur[0]        = in_cur;
  assign lk_prev[0]       = in_prev;
  assign lk_vel[0]        = in_vel;
  assign in_ready         = lk_ready[0];
  assign lk_ready[STAGES] = out_ready;
  assign out_valid        = lk_valid[STAGES];
  assign out_cur          = lk_cur[STAGES];
  assign out_prev         = lk_prev[STAGES];
  assign out_vel          = lk_vel[STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    wave_stage #(
      .LANES(LANES), .MAX_BEATS(MAX_BEATS), .MAX_ROWS(MAX_ROWS)
    ) u_stage (
      .clk      (clk),
      .rst      (rst),
      .cfg_beats(cfg_beats),
      .cfg_rows (cfg_rows),
      .in_valid (lk_valid[s]),
      .in_ready (lk_ready[s]),
      .in_cur   (lk_cur[s]),
      .in_prev  (lk_prev[s]),
      .in_vel   (lk_vel[s]),
      .out_valid(lk_valid[s+1]),
      .out_ready(lk_ready[s+1]),
      .out_cur  (lk_cur[s+1]),
      .out_prev (lk_prev[s+1]),
      .out_vel  (lk_vel[s+1])
    );
  end
endmodule

// File: rtl/wave_chain_chk.sv
`timescale 1ns/1ps
module wave_chain_chk #(
  parameter int LW = 96
)(
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [LW-1:0] out_cur,
  input logic [LW-1:0] out_prev,
  input logic [LW-1:0] out_vel
);
  logic [31:0] n_taken, n_given;

  always_ff @(posedge clk) begin
    if (rst) begin
      n_taken <= '0;
      n_given <= '0;
    end else begin
      n_taken <= n_taken + 32'(in_valid && in_ready);
      n_given <= n_given + 32'(out_valid && out_ready);
    end
  end

  // R8
  stall_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid);

  // R8
  stall_data_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> $stable(out_cur) && $stable(out_prev) && $stable(out_vel));

  // R9
  no_runahead_chk: assert property (@(posedge clk) disable iff (rst)
    n_given <= n_taken);

  // R10
  reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !out_valid);
endmodule

bind wave_stencil_chain wave_chain_chk #(.LW(LANES * wave_pkg::WORD_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_cur  (out_cur),
  .out_prev (out_prev),
  .out_vel  (out_vel)
);

// File: tb/wave_stencil_chain_test.sv
`timescale 1ns/1ps
module wave_stencil_chain_test;
  import wave_pkg::*;
  localparam int LANES = 4, STAGES = 3, MAX_BEATS = 8, MAX_ROWS = 8;
  localparam int COLS = MAX_BEATS * LANES, LW = LANES * WORD_W;
  localparam int BW = $clog2(MAX_BEATS + 1), RW = $clog2(MAX_ROWS + 1);
  localparam int FRAMES = 2, NCASE = 6;
  // beats, rows, seed, fill (0 full, 1 small, 2 clamp), stall pattern
  localparam int CASES [NCASE][5] = '{
    '{2, 4, 11, 1, 0},
    '{3, 5, 23, 0, 0},
    '{1, 6, 37, 1, 1},
    '{4, 3, 41, 2, 2},
    '{2, 2, 53, 0, 1},
    '{8, 8, 67, 1, 3}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [BW-1:0] cfg_beats;
  logic [RW-1:0] cfg_rows;
  logic in_valid, in_ready, out_valid, out_ready;
  logic [LW-1:0] in_cur, in_prev, in_vel, out_cur, out_prev, out_vel;
  logic [LW-1:0] hold_cur, hold_prev, hold_vel;

  always #10 clk = ~clk;

  wave_stencil_chain #(.LANES(LANES), .STAGES(STAGES), .MAX_BEATS(MAX_BEATS),
                       .MAX_ROWS(MAX_ROWS)) uut (.*);

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [31:0] lcg;
  int g_cur [FRAMES][MAX_ROWS][COLS];
  int g_prev[FRAMES][MAX_ROWS][COLS];
  int g_vel [FRAMES][MAX_ROWS][COLS];
  int e_cur [FRAMES][MAX_ROWS][COLS];
  int e_prev[FRAMES][MAX_ROWS][COLS];
  int wc[MAX_ROWS][COLS], wp[MAX_ROWS][COLS], wn[MAX_ROWS][COLS];

  function int draw();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return int'(lcg >> 8);
  endfunction

  // R1: 24-bit word to signed fraction code
  function automatic int sx(logic [WORD_W-1:0] w);
    return int'({{8{w[WORD_W-1]}}, w});
  endfunction

  function automatic int clamp(longint x);
    if (x > 64'sd8388607) return 8388607;
    if (x < -64'sd8388608) return -8388608;
    return int'(x);
  endfunction

  function automatic int interior(int c, int n, int s, int w, int e, int p, int v);
    longint lap, rp;
    lap = longint'(n) + s + w + e - 4 * longint'(c);
    rp  = (longint'(v) * lap + 64'sd4194304) >>> 23;
    return clamp(2 * longint'(c) - p + rp);
  endfunction

  task automatic count(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic build(int f, int beats, int rows, int fill);
    int cols = beats * LANES;
    for (int r = 0; r < rows; r++)
      for (int c = 0; c < cols; c++) begin
        if (fill == 2) begin
          g_cur[f][r][c]  = -8388608;
          g_prev[f][r][c] = 8388607;
          g_vel[f][r][c]  = sx(WORD_W'(draw()));
        end else if (fill == 1) begin
          g_cur[f][r][c]  = (draw() % 262144);
          g_prev[f][r][c] = (draw() % 262144);
          g_vel[f][r][c]  = (draw() % 4194304);
        end else begin
          g_cur[f][r][c]  = sx(WORD_W'(draw()));
          g_prev[f][r][c] = sx(WORD_W'(draw()));
          g_vel[f][r][c]  = sx(WORD_W'(draw()));
        end
        wc[r][c] = g_cur[f][r][c];
        wp[r][c] = g_prev[f][r][c];
      end
    // R7: STAGES successive steps; R4 edges keep the present value
    for (int s = 0; s < STAGES; s++) begin
      for (int r = 0; r < rows; r++)
        for (int c = 0; c < cols; c++) begin
          if (r == 0 || r == rows - 1 || c == 0 || c == cols - 1)
            wn[r][c] = wc[r][c];
          else
            wn[r][c] = interior(wc[r][c], wc[r-1][c], wc[r+1][c], wc[r][c-1],
                                wc[r][c+1], wp[r][c], g_vel[f][r][c]);
        end
      for (int r = 0; r < rows; r++)
        for (int c = 0; c < cols; c++) begin
          wp[r][c] = wc[r][c];
          wc[r][c] = wn[r][c];
        end
    end
    for (int r = 0; r < rows; r++)
      for (int c = 0; c < cols; c++) begin
        e_cur[f][r][c]  = wc[r][c];
        e_prev[f][r][c] = wp[r][c];
      end
  endtask

  task automatic run_case(int ci);
    int beats = CASES[ci][0], rows = CASES[ci][1], fill = CASES[ci][3];
    int stall = CASES[ci][4];
    int nb, total, iidx, oidx, lim, rv;
    bit held, bad;
    lcg = 32'(CASES[ci][2]);
    cfg_beats = BW'(beats);
    cfg_rows  = RW'(rows);
    for (int f = 0; f < FRAMES; f++) build(f, beats, rows, fill);
    nb = beats * rows;
    total = FRAMES * nb;
    iidx = 0; oidx = 0; lim = 0; held = 0;
    while (oidx < total && lim < 20000) begin
      @(negedge clk);
      lim++;
      if (held) begin
        // R8: stalled output holds
        count(out_valid && out_cur == hold_cur && out_prev == hold_prev &&
              out_vel == hold_vel, "R8", "held beat changed", int'(out_valid), 1);
      end
      rv = draw();
      case (stall)
        1: begin in_valid = (lim % 3 != 0); out_ready = (lim % 2 == 0); end
        2: begin in_valid = 1'b1; out_ready = (lim % 7) >= 5; end
        3: begin in_valid = (rv & 1) != 0; out_ready = ((rv >> 1) & 3) != 0; end
        default: begin in_valid = 1'b1; out_ready = 1'b1; end
      endcase
      if (iidx >= total) in_valid = 1'b0;
      else begin
        int f = iidx / nb, b = iidx % nb;
        for (int l = 0; l < LANES; l++) begin
          in_cur [l*WORD_W +: WORD_W] = WORD_W'(g_cur [f][b/beats][(b%beats)*LANES+l]);
          in_prev[l*WORD_W +: WORD_W] = WORD_W'(g_prev[f][b/beats][(b%beats)*LANES+l]);
          in_vel [l*WORD_W +: WORD_W] = WORD_W'(g_vel [f][b/beats][(b%beats)*LANES+l]);
        end
      end
      #9;
      if (in_valid && in_ready) iidx++;
      held = out_valid && !out_ready;
      hold_cur = out_cur; hold_prev = out_prev; hold_vel = out_vel;
      if (out_valid && out_ready) begin
        int f = oidx / nb, b = oidx % nb, r = (oidx % nb) / beats;
        for (int l = 0; l < LANES; l++) begin
          int c = (b % beats) * LANES + l;
          int a = sx(out_cur[l*WORD_W +: WORD_W]), e = e_cur[f][r][c];
          string tg;
          if (r == 0 || r == rows - 1 || c == 0 || c == beats * LANES - 1) tg = "R4 R6";
          else if (e == 8388607 || e == -8388608) tg = "R3 R6";
          else tg = "R2 R7";
          count(a == e, tg, $sformatf("out_cur row %0d col %0d", r, c), a, e);
          a = sx(out_prev[l*WORD_W +: WORD_W]);
          count(a == e_prev[f][r][c], "R5", "out_prev", a, e_prev[f][r][c]);
          a = sx(out_vel[l*WORD_W +: WORD_W]);
          count(a == g_vel[f][r][c], "R1 R5", "out_vel", a, g_vel[f][r][c]);
        end
        oidx++;
      end
    end
    count(oidx == total && iidx == total, "R9", "beats delivered", oidx, total);
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    bad = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (out_valid) bad = 1;
    end
    count(!bad, "R9", "extra beat after frames", int'(bad), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    in_valid = 1'b0; out_ready = 1'b0;
    in_cur = '0; in_prev = '0; in_vel = '0;
    cfg_beats = BW'(2); cfg_rows = RW'(3);
    repeat (3) @(negedge clk);
    count(!out_valid, "R10", "out_valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    count(!out_valid && in_ready, "R10", "idle after reset",
          int'({out_valid, in_ready}), 1);
    for (int ci = 0; ci < NCASE; ci++) run_case(ci);

    // reset in the middle of a frame, then a clean frame
    cfg_beats = BW'(2); cfg_rows = RW'(4);
    out_ready = 1'b0; in_valid = 1'b1; in_cur = {LANES{24'h012345}};
    repeat (9) @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    count(!out_valid && in_ready, "R10", "flush by reset mid-frame",
          int'({out_valid, in_ready}), 1);
    run_case(0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule